// File: doc/BRIEF.md
# CFI Geometry Discovery Engine

This block runs a parameter query against a NOR-type flash device that sits on a 16-bit memory-style host bus. After a start pulse it puts the device into query mode and confirms the three-word query signature. It then reads the device size exponent and the number of erase regions, and fetches a four-word descriptor for each region. From these descriptors it works out how many erase blocks each region has and how many bytes each block holds, and it adds up the total capacity. At the end it sends the device back to array-read mode.

The host bus uses byte addresses. The device's address pin 0 is wired to host address bit 1, so every word address the engine wants is issued as twice that value. Each access holds a single read or write strobe until the bus answers with ready. When the sequence ends, a one-cycle done pulse is raised together with either valid (signature good, region count acceptable, summed region capacity equal to the declared device size) or err. The decoded geometry stays on the outputs until the next start.

Top module: `cfi_geom_engine`

## Requirements
- R1: After start, the first bus transaction is a write of 0x0098 to byte address 0x0AA (word 0x55).
- R2: Word addresses 0x10, 0x11 and 0x12 (byte addresses 0x20, 0x22, 0x24) are read next, and the full 16-bit values must be 0x0051, 0x0052 and 0x0059. If any of them differs, no further reads are made and the run ends with err=1, valid=0.
- R3: The low byte of word 0x27 (byte 0x4E) is the size exponent n, and it is shown on dev_size_log2. The declared device size is 2^n bytes.
- R4: The low byte of word 0x2C (byte 0x58) is the region count, shown on region_count. A count of 0, or one above MAX_REGIONS (4), ends the run with err=1 and no descriptor reads.
- R5: Region i's descriptor is in words 0x2D+4i through 0x30+4i, using the low byte of each. Its block count is {byte of word 0x2E+4i, byte of word 0x2D+4i}+1, given on region_blocks[i*17 +: 17].
- R6: Region i's sector size in bytes is 256 × {byte of word 0x30+4i, byte of word 0x2F+4i}, given on region_sector_bytes[i*24 +: 24].
- R7: total_bytes is the sum over the read regions of block count × sector size. valid=1 only when the signature and region count are good and total_bytes equals 2^n (n at or above 48 never matches); otherwise err=1. valid and err are never both high.
- R8: Every issued byte address is twice the intended word address, so bit 0 is always zero.
- R9: The last transaction of every run is a write of 0x00F0 that returns the device to read mode. done is a one-cycle pulse two cycles after that write completes, and valid and err keep their values until the next start.
- R10: Only one of bus_rd and bus_wr is high at any time. The strobe, address and write data stay steady until bus_ready is sampled high, and the strobe drops in the next cycle.
- R11: A start pulse that arrives while a run is in progress has no effect: the run's transaction counts and its results are unchanged.
- R12: At start, all results are cleared. Regions that were not read report zero blocks and zero sector bytes, and total_bytes covers only the regions that were read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that launches a discovery run |
| bus_addr | output | ADDR_W (24) | Byte address, equal to the word address times two |
| bus_wdata | output | 16 | Write data |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_rdata | input | 16 | Read data, valid in the ready cycle |
| bus_ready | input | 1 | Completes the current access |
| done | output | 1 | One-cycle pulse at the end of a run |
| valid | output | 1 | Geometry is consistent |
| err | output | 1 | Query unsupported, bad region count, or capacity mismatch |
| dev_size_log2 | output | 8 | Size exponent n that was read |
| region_count | output | 8 | Region count field that was read |
| region_blocks | output | MAX_REGIONS*17 | Block count for each region |
| region_sector_bytes | output | MAX_REGIONS*24 | Sector size in bytes for each region |
| total_bytes | output | TOT_W (48) | Summed capacity of the read regions |

## Verification
The hardest situation to reach from the ports is a region table whose sum lands exactly on a power of two, because random descriptors almost never do. The stimulus builds such tables on purpose: it picks one region with a power-of-two block count and a power-of-two size and sets n to match, and it also drives the four-region 2 MiB layout directly. A second hard case is a start pulse in the middle of a run, which should only be seen through unchanged transaction counts. The bench fires one partway through a run and counts every access its bus model serves.

// File: rtl/cfi_geom_pkg.sv
package cfi_geom_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ENTER,
      ST_SIG,
      ST_SIZE,
      ST_NREG,
      ST_DESC,
      ST_EXIT
   } seq_state_t;

   localparam int WA_W = 8;

   localparam logic [WA_W-1:0] WA_QUERY_CMD = 8'h55;
   localparam logic [WA_W-1:0] WA_SIG_BASE  = 8'h10;
   localparam logic [WA_W-1:0] WA_SIZE_EXP  = 8'h27;
   localparam logic [WA_W-1:0] WA_REG_COUNT = 8'h2C;
   localparam logic [WA_W-1:0] WA_DESC_BASE = 8'h2D;
   localparam logic [WA_W-1:0] WA_READ_MODE = 8'h00;

   localparam logic [15:0] CMD_QUERY     = 16'h0098;
   localparam logic [15:0] CMD_READ_MODE = 16'h00F0;

   function automatic logic [15:0] sig_word(input logic [1:0] pos);
      case (pos)
         2'd0:    sig_word = 16'h0051;
         2'd1:    sig_word = 16'h0052;
         default: sig_word = 16'h0059;
      endcase
   endfunction

endpackage

// File: rtl/cfi_bus_port.sv
module cfi_bus_port #(
   parameter int ADDR_W = 24,
   parameter int WA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [WA_W-1:0]   req_waddr,
   input  logic [15:0]       req_wdata,
   output logic              ack,
   output logic [15:0]       rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [15:0]       bus_wdata,
   output logic              bus_wr,
   output logic              bus_rd,
   input  logic [15:0]       bus_rdata,
   input  logic              bus_ready
);

   logic active;
   assign active = bus_wr | bus_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_addr  <= '0;
         bus_wdata <= '0;
         bus_wr    <= 1'b0;
         bus_rd    <= 1'b0;
         ack       <= 1'b0;
         rdata     <= '0;
      end else begin
         ack <= 1'b0;
         if (active) begin
            if (bus_ready) begin
               bus_wr <= 1'b0;
               bus_rd <= 1'b0;
               ack    <= 1'b1;
               if (bus_rd) rdata <= bus_rdata;
            end
         end else if (req && !ack) begin
            bus_wr    <= req_wr;
            bus_rd    <= !req_wr;
            bus_addr  <= ADDR_W'({req_waddr, 1'b0});
            bus_wdata <= req_wdata;
         end
      end
   end

endmodule

// File: rtl/cfi_region_store.sv
module cfi_region_store #(
   parameter int MAX_REGIONS = 4,
   parameter int CNT_W       = 17,
   parameter int SEC_W       = 24,
   localparam int RI_W       = (MAX_REGIONS > 1) ? $clog2(MAX_REGIONS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         wr_en,
   input  logic [RI_W-1:0]              wr_region,
   input  logic [1:0]                   wr_field,
   input  logic [7:0]                   wr_byte,
   output logic [MAX_REGIONS*CNT_W-1:0] blocks_flat,
   output logic [MAX_REGIONS*SEC_W-1:0] sector_flat
);

   for (genvar g = 0; g < MAX_REGIONS; g++) begin : g_region
      logic [7:0] cnt_lo, cnt_hi, sz_lo, sz_hi;
      logic       loaded;
      logic       hit;

      assign hit = wr_en && (wr_region == RI_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            sz_lo  <= '0;
            sz_hi  <= '0;
            loaded <= 1'b0;
         end else if (clear) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            sz_lo  <= '0;
            sz_hi  <= '0;
            loaded <= 1'b0;
         end else if (hit) begin
            case (wr_field)
               2'd0: cnt_lo <= wr_byte;
               2'd1: cnt_hi <= wr_byte;
               2'd2: sz_lo  <= wr_byte;
               default: begin
                  sz_hi  <= wr_byte;
                  loaded <= 1'b1;
               end
            endcase
         end
      end

      assign blocks_flat[g*CNT_W +: CNT_W] =
         loaded ? (CNT_W'({cnt_hi, cnt_lo}) + CNT_W'(1)) : '0;
      assign sector_flat[g*SEC_W +: SEC_W] =
         loaded ? SEC_W'({sz_hi, sz_lo, 8'h00}) : '0;
   end

endmodule

// File: rtl/cfi_capacity_sum.sv
module cfi_capacity_sum #(
   parameter int MAX_REGIONS = 4,
   parameter int CNT_W       = 17,
   parameter int SEC_W       = 24,
   parameter int TOT_W       = 48
) (
   input  logic [MAX_REGIONS*CNT_W-1:0] blocks_flat,
   input  logic [MAX_REGIONS*SEC_W-1:0] sector_flat,
   input  logic [7:0]                   size_log2,
   output logic [TOT_W-1:0]             total,
   output logic                         match
);

   logic [TOT_W-1:0] prod [MAX_REGIONS];
   logic [TOT_W-1:0] declared;

   for (genvar g = 0; g < MAX_REGIONS; g++) begin : g_prod
      assign prod[g] = TOT_W'(blocks_flat[g*CNT_W +: CNT_W])
                     * TOT_W'(sector_flat[g*SEC_W +: SEC_W]);
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < MAX_REGIONS; i++) total = total + prod[i];
   end

   always_comb begin
      if (32'(size_log2) < TOT_W) declared = TOT_W'(1) << size_log2;
      else                        declared = '0;
   end

   assign match = (declared != '0) && (total == declared);

endmodule

// File: rtl/cfi_geom_engine.sv
module cfi_geom_engine
   import cfi_geom_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int MAX_REGIONS = 4,
   parameter int CNT_W       = 17,
   parameter int SEC_W       = 24,
   parameter int TOT_W       = 48
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   output logic [ADDR_W-1:0]            bus_addr,
   output logic [15:0]                  bus_wdata,
   output logic                         bus_wr,
   output logic                         bus_rd,
   input  logic [15:0]                  bus_rdata,
   input  logic                         bus_ready,
   output logic                         done,
   output logic                         valid,
   output logic                         err,
   output logic [7:0]                   dev_size_log2,
   output logic [7:0]                   region_count,
   output logic [MAX_REGIONS*CNT_W-1:0] region_blocks,
   output logic [MAX_REGIONS*SEC_W-1:0] region_sector_bytes,
   output logic [TOT_W-1:0]             total_bytes
);

   localparam int RI_W = (MAX_REGIONS > 1) ? $clog2(MAX_REGIONS) : 1;
   localparam int SUM_W = CNT_W + SEC_W + RI_W + 1;

   if (MAX_REGIONS < 1 || MAX_REGIONS > 8) begin : g_chk_regions
      $error("MAX_REGIONS must lie in 1..8");
   end
   if (CNT_W < 17) begin : g_chk_cnt
      $error("CNT_W must hold a 16-bit field plus one");
   end
   if (SEC_W < 24) begin : g_chk_sec
      $error("SEC_W must hold 256 times a 16-bit field");
   end
   if (TOT_W < SUM_W) begin : g_chk_tot
      $error("TOT_W too narrow for the summed capacity");
   end
   if (ADDR_W < WA_W + 1) begin : g_chk_addr
      $error("ADDR_W too narrow for the doubled word address");
   end

   seq_state_t      state;
   logic [1:0]      sig_idx;
   logic [RI_W-1:0] reg_idx;
   logic [1:0]      field_idx;
   logic            fail;
   logic [7:0]      nreg_q;
   logic [7:0]      nlog_q;

   logic            req, req_wr, ack;
   logic [WA_W-1:0] req_waddr;
   logic [15:0]     req_wdata, rdata;
   logic            cap_match;
   logic            sig_miss;

   always_comb begin
      req       = (state != ST_IDLE);
      req_wr    = (state == ST_ENTER) || (state == ST_EXIT);
      req_wdata = (state == ST_ENTER) ? CMD_QUERY : CMD_READ_MODE;
      case (state)
         ST_ENTER: req_waddr = WA_QUERY_CMD;
         ST_SIG:   req_waddr = WA_SIG_BASE + WA_W'(sig_idx);
         ST_SIZE:  req_waddr = WA_SIZE_EXP;
         ST_NREG:  req_waddr = WA_REG_COUNT;
         ST_DESC:  req_waddr = WA_DESC_BASE + WA_W'({reg_idx, 2'b00}) + WA_W'(field_idx);
         default:  req_waddr = WA_READ_MODE;
      endcase
   end

   assign sig_miss = (rdata != sig_word(sig_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sig_idx   <= '0;
         reg_idx   <= '0;
         field_idx <= '0;
         fail      <= 1'b0;
         nreg_q    <= '0;
         nlog_q    <= '0;
         done      <= 1'b0;
         valid     <= 1'b0;
         err       <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state     <= ST_ENTER;
                  sig_idx   <= '0;
                  reg_idx   <= '0;
                  field_idx <= '0;
                  fail      <= 1'b0;
                  nreg_q    <= '0;
                  nlog_q    <= '0;
                  valid     <= 1'b0;
                  err       <= 1'b0;
               end
            end
            ST_ENTER: if (ack) state <= ST_SIG;
            ST_SIG: begin
               if (ack) begin
                  sig_idx <= sig_idx + 2'd1;
                  if (sig_miss) fail <= 1'b1;
                  if (sig_idx == 2'd2)
                     state <= (fail || sig_miss) ? ST_EXIT : ST_SIZE;
               end
            end
            ST_SIZE: begin
               if (ack) begin
                  nlog_q <= rdata[7:0];
                  state  <= ST_NREG;
               end
            end
            ST_NREG: begin
               if (ack) begin
                  nreg_q <= rdata[7:0];
                  if (rdata[7:0] == 8'd0 || rdata[7:0] > 8'(MAX_REGIONS)) begin
                     fail  <= 1'b1;
                     state <= ST_EXIT;
                  end else begin
                     state <= ST_DESC;
                  end
               end
            end
            ST_DESC: begin
               if (ack) begin
                  field_idx <= field_idx + 2'd1;
                  if (field_idx == 2'd3) begin
                     if (8'(reg_idx) == nreg_q - 8'd1) state <= ST_EXIT;
                     else reg_idx <= reg_idx + RI_W'(1);
                  end
               end
            end
            ST_EXIT: begin
               if (ack) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
                  valid <= !fail && cap_match;
                  err   <= fail || !cap_match;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   cfi_bus_port #(
      .ADDR_W (ADDR_W),
      .WA_W   (WA_W)
   ) i_bus_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_wr    (req_wr),
      .req_waddr (req_waddr),
      .req_wdata (req_wdata),
      .ack       (ack),
      .rdata     (rdata),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .bus_ready (bus_ready)
   );

   cfi_region_store #(
      .MAX_REGIONS (MAX_REGIONS),
      .CNT_W       (CNT_W),
      .SEC_W       (SEC_W)
   ) i_region_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (start && state == ST_IDLE),
      .wr_en       (ack && state == ST_DESC),
      .wr_region   (reg_idx),
      .wr_field    (field_idx),
      .wr_byte     (rdata[7:0]),
      .blocks_flat (region_blocks),
      .sector_flat (region_sector_bytes)
   );

   cfi_capacity_sum #(
      .MAX_REGIONS (MAX_REGIONS),
      .CNT_W       (CNT_W),
      .SEC_W       (SEC_W),
      .TOT_W       (TOT_W)
   ) i_capacity_sum (
      .blocks_flat (region_blocks),
      .sector_flat (region_sector_bytes),
      .size_log2   (nlog_q),
      .total       (total_bytes),
      .match       (cap_match)
   );

   assign dev_size_log2 = nlog_q;
   assign region_count  = nreg_q;

endmodule

// File: rtl/cfi_geom_engine_chk.sv
module cfi_geom_engine_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [15:0]       bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              bus_ready,
   input logic              done,
   input logic              valid,
   input logic              err
);

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr)); // R10

   AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && !bus_ready) |=>
         ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr) && $stable(bus_wdata))); // R10

   AST_DROP_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && bus_ready) |=> !(bus_rd || bus_wr)); // R10

   AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> (bus_addr[0] == 1'b0)); // R8

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && err)); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bus_wr && bus_ready && (bus_wdata == 16'h00F0), 2)); // R9

   AST_DONE_HAS_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot({valid, err})); // R7

endmodule

bind cfi_geom_engine cfi_geom_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_ready (bus_ready),
   .done      (done),
   .valid     (valid),
   .err       (err)
);

// File: tb/test_cfi_geom_engine.sv
`timescale 1ns/1ps
module test_cfi_geom_engine;

   localparam int ADDR_W = 24;
   localparam int MR     = 4;
   localparam int CNT_W  = 17;
   localparam int SEC_W  = 24;
   localparam int TOT_W  = 48;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  start = 1'b0;
   logic [ADDR_W-1:0]     bus_addr;
   logic [15:0]           bus_wdata;
   logic                  bus_wr, bus_rd;
   logic [15:0]           bus_rdata = 16'h0000;
   logic                  bus_ready = 1'b0;
   logic                  done, valid, err;
   logic [7:0]            dev_size_log2, region_count;
   logic [MR*CNT_W-1:0]   region_blocks;
   logic [MR*SEC_W-1:0]   region_sector_bytes;
   logic [TOT_W-1:0]      total_bytes;

   always #4 clk = ~clk;

   cfi_geom_engine #(
      .ADDR_W(ADDR_W), .MAX_REGIONS(MR), .CNT_W(CNT_W), .SEC_W(SEC_W), .TOT_W(TOT_W)
   ) i_cfi_geom_engine (
      .clk(clk), .rst_n(rst_n), .start(start),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .done(done), .valid(valid), .err(err),
      .dev_size_log2(dev_size_log2), .region_count(region_count),
      .region_blocks(region_blocks), .region_sector_bytes(region_sector_bytes),
      .total_bytes(total_bytes)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // device configuration
   logic [15:0] sig_cfg [3];
   int          n_cfg;
   int          nreg_cfg;
   int          cnt_m1 [MR];
   int          szf [MR];

   // bus model bookkeeping
   bit              qmode = 0;
   int              rd_cnt, wr_cnt, odd_cnt;
   logic [ADDR_W-1:0] first_wa;
   logic [15:0]     first_wd, last_wd;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [15:0] cfi_word(input int wa);
      int r, f;
      if (wa >= 16'h10 && wa <= 16'h12) return sig_cfg[wa - 16'h10];
      if (wa == 16'h27) return 16'(n_cfg & 8'hFF);
      if (wa == 16'h2C) return 16'(nreg_cfg & 8'hFF);
      if (wa >= 16'h2D && wa < 16'h2D + 4 * MR) begin
         r = (wa - 16'h2D) / 4;
         f = (wa - 16'h2D) % 4;
         case (f)
            0: return 16'(cnt_m1[r] & 8'hFF);
            1: return 16'((cnt_m1[r] >> 8) & 8'hFF);
            2: return 16'(szf[r] & 8'hFF);
            default: return 16'((szf[r] >> 8) & 8'hFF);
         endcase
      end
      return 16'h0000;
   endfunction

   // bus responder
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && (bus_rd || bus_wr)) begin
            repeat ($urandom % 3) @(negedge clk);
            if (bus_addr[0]) odd_cnt++;
            if (bus_wr) begin
               if (wr_cnt == 0) begin
                  first_wa = bus_addr;
                  first_wd = bus_wdata;
               end
               last_wd = bus_wdata;
               wr_cnt++;
               if (bus_wdata == 16'h0098 && bus_addr == 24'h0000AA) qmode = 1;
               if (bus_wdata == 16'h00F0) qmode = 0;
            end else begin
               rd_cnt++;
               bus_rdata = qmode ? cfi_word(int'(bus_addr >> 1)) : 16'hFFFF;
            end
            bus_ready = 1'b1;
            @(negedge clk);
            bus_ready = 1'b0;
         end
      end
   end

   task automatic run_case(input string name, input bit dup_start);
      bit     sig_ok, nreg_ok, exp_valid, got_done;
      longint tot, blk, sec;
      int     exp_rd;
      rd_cnt = 0; wr_cnt = 0; odd_cnt = 0;
      first_wa = '0; first_wd = '0; last_wd = '0;
      sig_ok  = (sig_cfg[0] == 16'h0051) && (sig_cfg[1] == 16'h0052) && (sig_cfg[2] == 16'h0059);
      nreg_ok = sig_ok && (nreg_cfg >= 1) && (nreg_cfg <= MR);
      tot = 0;
      if (nreg_ok)
         for (int i = 0; i < nreg_cfg; i++)
            tot += longint'(cnt_m1[i] + 1) * longint'(szf[i]) * 256;
      exp_valid = nreg_ok && (n_cfg < TOT_W) && (tot == (longint'(1) << n_cfg));
      exp_rd = !sig_ok ? 3 : (!nreg_ok ? 5 : 5 + 4 * nreg_cfg);

      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (dup_start) begin
         repeat (12) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      got_done = 0;
      for (int c = 0; c < 3000 && !got_done; c++) begin
         if (done) got_done = 1;
         else @(negedge clk);
      end
      chk(got_done, {name, " R9 done seen"}, got_done, 1);
      @(negedge clk);
      chk(done == 1'b0, {name, " R9 done one cycle"}, done, 0);
      chk(valid == exp_valid, {name, " R7 valid"}, valid, exp_valid);
      chk(err == !exp_valid, {name, " R7 err"}, err, !exp_valid);
      chk(first_wa == 24'hAA && first_wd == 16'h0098, {name, " R1 entry write"},
          {first_wa, first_wd}, {24'hAA, 16'h0098});
      chk(rd_cnt == exp_rd, {name, " R2 R4 R11 read count"}, rd_cnt, exp_rd);
      chk(wr_cnt == 2, {name, " R11 write count"}, wr_cnt, 2);
      chk(last_wd == 16'h00F0 && qmode == 0, {name, " R9 exit to read mode"}, last_wd, 16'h00F0);
      chk(odd_cnt == 0, {name, " R8 even byte addresses"}, odd_cnt, 0);
      chk(dev_size_log2 == (sig_ok ? 8'(n_cfg) : 8'd0), {name, " R3 size exponent"},
          dev_size_log2, sig_ok ? n_cfg : 0);
      chk(region_count == (sig_ok ? 8'(nreg_cfg) : 8'd0), {name, " R4 region count"},
          region_count, sig_ok ? nreg_cfg : 0);
      for (int i = 0; i < MR; i++) begin
         blk = (nreg_ok && i < nreg_cfg) ? longint'(cnt_m1[i] + 1) : 0;
         sec = (nreg_ok && i < nreg_cfg) ? longint'(szf[i]) * 256 : 0;
         chk(longint'(region_blocks[i*CNT_W +: CNT_W]) == blk, {name, " R5 R12 blocks"},
             region_blocks[i*CNT_W +: CNT_W], blk);
         chk(longint'(region_sector_bytes[i*SEC_W +: SEC_W]) == sec, {name, " R6 R12 sector bytes"},
             region_sector_bytes[i*SEC_W +: SEC_W], sec);
      end
      chk(longint'(total_bytes) == tot, {name, " R7 total"}, total_bytes, tot);
      repeat (3) @(negedge clk);
      chk(valid == exp_valid && err == !exp_valid, {name, " R9 flags held"}, {valid, err}, {exp_valid, !exp_valid});
   endtask

   task automatic good_sig();
      sig_cfg[0] = 16'h0051; sig_cfg[1] = 16'h0052; sig_cfg[2] = 16'h0059;
   endtask

   task automatic clear_regions();
      for (int i = 0; i < MR; i++) begin cnt_m1[i] = 0; szf[i] = 0; end
   endtask

   initial begin
      int a, b, pick;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !valid && !err, "reset R9 flags low", {done, valid, err}, 0);
      chk(!bus_rd && !bus_wr, "reset R10 strobes low", {bus_rd, bus_wr}, 0);
      chk(total_bytes == '0 && region_blocks == '0, "reset R12 results zero", total_bytes, 0);

      // four-region 2 MiB layout
      good_sig(); clear_regions();
      n_cfg = 8'h15; nreg_cfg = 4;
      cnt_m1[0] = 0;    szf[0] = 16'h0040;
      cnt_m1[1] = 1;    szf[1] = 16'h0020;
      cnt_m1[2] = 0;    szf[2] = 16'h0080;
      cnt_m1[3] = 8'h1E; szf[3] = 16'h0100;
      run_case("2MiB", 0);

      // same layout, extra start mid-run
      run_case("dup_start", 1);

      // capacity mismatch
      n_cfg = 8'h16;
      run_case("cap_mismatch", 0);

      // bad signatures, incl. upper byte set
      good_sig(); sig_cfg[2] = 16'h0058; n_cfg = 8'h15;
      run_case("bad_Y", 0);
      good_sig(); sig_cfg[0] = 16'h0151;
      run_case("bad_Q_upper", 0);

      // region count limits
      good_sig(); nreg_cfg = 0;
      run_case("nreg0", 0);
      nreg_cfg = 5;
      run_case("nreg5", 0);

      // fewer regions than maximum, stale clearing
      clear_regions(); nreg_cfg = 1; cnt_m1[0] = 16'h00FF; szf[0] = 16'h0100;
      n_cfg = 24;
      run_case("one_region", 0);

      // maximum fields, exponent beyond width
      clear_regions(); nreg_cfg = 4;
      for (int i = 0; i < MR; i++) begin cnt_m1[i] = 16'hFFFF; szf[i] = 16'hFFFF; end
      n_cfg = 48;
      run_case("max_fields", 0);

      // random mix
      for (int t = 0; t < 24; t++) begin
         good_sig(); clear_regions();
         pick = $urandom % 4;
         if (pick == 0) begin
            a = $urandom % 10; b = $urandom % 10;
            nreg_cfg = 1; cnt_m1[0] = (1 << a) - 1; szf[0] = 1 << b;
            n_cfg = a + b + 8;
         end else begin
            nreg_cfg = 1 + ($urandom % MR);
            for (int i = 0; i < nreg_cfg; i++) begin
               cnt_m1[i] = $urandom % 16'h0100;
               szf[i] = 1 + ($urandom % 16'h0200);
            end
            n_cfg = 14 + ($urandom % 16);
            if (pick == 3) sig_cfg[$urandom % 3] = 16'($urandom);
         end
         run_case($sformatf("rand%0d", t), (t % 7) == 3);
      end

      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog R9 actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule